// File: doc/BRIEF.md
# Serial Word Receiver with Companding Expansion

The block takes a serial data line, a frame-sync line and a serial clock. It turns each framed bit stream into a 32-bit parallel word that is ready for the processor side. The serial clock is not used as a clock. Both candidate serial clocks are sampled in the system clock domain, and the chosen transition of the selected one acts as a sampling enable. A frame-sync seen on that transition starts a word, and the data bit present on the same transition becomes its first bit.

A control set is captured at each frame start. It holds the word length, the bit order, the formatting mode and whether packing is on. A finished word is placed right-justified and then either zero-filled, sign-extended, or expanded from an 8-bit G.711 code into a signed linear value. When packing is on, two consecutive words share one output: the low 16 bits of the first formatted word form the lower half and those of the second form the upper half. Each output word is announced by a single-cycle strobe.

Top module: `serrx_top`

## Requirements
- R1: While reset is asserted and after it is released, `rx_valid` is 0 and `rx_data` is 0 until the first word completes.
- R2: A frame-sync sampled high on the active serial-clock transition starts a word, and the data bit on that same transition is its first bit. The word holds `ctl_len`+1 bits. Field values 0 and 1 give a 3-bit word, and value 31 gives a 32-bit word.
- R3: With `ctl_lsb_first`=0 the first serial bit is the most significant bit of the word. With `ctl_lsb_first`=1 it is the least significant bit.
- R4: With `ctl_rise`=1, frame-sync and data are sampled on rising transitions of the serial clock. With `ctl_rise`=0 they are sampled on falling transitions. Values present on the other transition are ignored.
- R5: With `ctl_int_clk`=0 the receiver uses `sclk_ext`, and with `ctl_int_clk`=1 it uses `sclk_int`. The clock that is not selected has no effect.
- R6: `ctl_fmt`=00 outputs the word right-justified with all bits above the word length set to 0.
- R7: `ctl_fmt`=01 outputs the word right-justified with all bits above the word length equal to the word's top bit.
- R8: `ctl_fmt`=10 reads 8 bits whatever `ctl_len` holds and expands them by the G.711 mu-law rule to a signed 16-bit value, sign-extended to 32 bits. Codes 0xFF, 0x80 and 0x00 give 0, 0x00007D7C and 0xFFFF8284.
- R9: `ctl_fmt`=11 reads 8 bits and expands them by the G.711 A-law rule to a signed 16-bit value, sign-extended to 32 bits. Codes 0xD5, 0xAA and 0x2A give 0x00000008, 0x00007E00 and 0xFFFF8200.
- R10: With `ctl_pack`=1 the first word produces no strobe. The second word produces one strobe with `rx_data` = {second[15:0], first[15:0]}, where both halves are taken from the formatted words.
- R11: A frame-sync that arrives while a word is in progress discards the partial word without a strobe and starts a new word, taking the current bit as its first bit.
- R12: Length, bit order, format and packing are taken from the control inputs only at a frame start. Changing them mid-word does not affect the word in progress.
- R13: `rx_valid` is high for exactly one system clock cycle per output word. `rx_data` keeps its value between strobes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_fmt | input | 2 | Formatting mode: 00 zero-fill, 01 sign-extend, 10 mu-law, 11 A-law |
| ctl_lsb_first | input | 1 | Bit order: 1 means the first serial bit is the LSB |
| ctl_len | input | 5 | Word length minus one |
| ctl_pack | input | 1 | Pack two words into one output |
| ctl_rise | input | 1 | Sampling transition: 1 rising, 0 falling |
| ctl_int_clk | input | 1 | Serial clock source: 1 internal, 0 external |
| sclk_ext | input | 1 | External serial clock, sampled by clk |
| sclk_int | input | 1 | Internal serial clock, sampled by clk |
| fs_in | input | 1 | Frame-sync |
| sd_in | input | 1 | Serial data |
| rx_data | output | 32 | Formatted received word |
| rx_valid | output | 1 | One-cycle strobe marking a new rx_data |

## Verification
The properties assume that the selected serial clock holds each level for at least two system clock cycles. This keeps two sampling transitions from falling in back-to-back cycles. They also assume that frame-sync and data are steady across the cycle in which that clock changes, and that control inputs change only while no word is expected to depend on them. Every stimulus phase (setting data, the active transition, scrambling data, the inactive transition) is held for three system clock cycles. Data and frame-sync are deliberately inverted around the inactive transition, so sampling on the wrong transition or from the wrong clock leads to different words.

// File: rtl/serrx_pkg.sv
package serrx_pkg;

  parameter int unsigned SRX_DW  = 32;
  localparam int unsigned SRX_LW = $clog2(SRX_DW);
  localparam int unsigned SRX_NW = SRX_LW + 1;
  localparam int unsigned SRX_HW = SRX_DW / 2;
  localparam int unsigned SRX_CW = 8;

  typedef enum logic [1:0] {
    FMT_ZERO  = 2'b00,
    FMT_SIGN  = 2'b01,
    FMT_MULAW = 2'b10,
    FMT_ALAW  = 2'b11
  } fmt_e;

  typedef struct packed {
    fmt_e              fmt;
    logic              lsb_first;
    logic              pack;
    logic [SRX_NW-1:0] nbits;
  } frame_cfg_t;

  function automatic logic [15:0] mulaw_to_lin(input logic [7:0] code);
    logic [7:0]  u;
    logic [15:0] t;
    logic [15:0] mag;
    u   = ~code;
    t   = ({12'd0, u[3:0]} << 3) + 16'd132;
    t   = t << u[6:4];
    mag = t - 16'd132;
    return u[7] ? (16'd0 - mag) : mag;
  endfunction

  function automatic logic [15:0] alaw_to_lin(input logic [7:0] code);
    logic [7:0]  a;
    logic [15:0] t;
    a = code ^ 8'h55;
    t = {8'd0, a[3:0], 4'd0};
    if (a[6:4] == 3'd0) t = t + 16'd8;
    else                t = (t + 16'd264) << (a[6:4] - 3'd1);
    return a[7] ? t : (16'd0 - t);
  endfunction

endpackage

// File: rtl/serrx_edge.sv
module serrx_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_ext,
  input  logic sclk_int,
  input  logic sel_int,
  input  logic rise_sel,
  input  logic fs_in,
  input  logic sd_in,
  output logic smp_stb,
  output logic smp_fs,
  output logic smp_bit
);

  logic sclk_sel;
  logic sclk_q, sclk_q2, fs_q, sd_q;

  assign sclk_sel = sel_int ? sclk_int : sclk_ext;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q  <= 1'b0;
      sclk_q2 <= 1'b0;
      fs_q    <= 1'b0;
      sd_q    <= 1'b0;
    end else begin
      sclk_q  <= sclk_sel;
      sclk_q2 <= sclk_q;
      fs_q    <= fs_in;
      sd_q    <= sd_in;
    end
  end

  always_comb begin
    if (rise_sel) smp_stb = sclk_q & ~sclk_q2;
    else          smp_stb = ~sclk_q & sclk_q2;
  end

  assign smp_fs  = fs_q;
  assign smp_bit = sd_q;

endmodule

// File: rtl/serrx_shift.sv
module serrx_shift
  import serrx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_stb,
  input  logic              smp_fs,
  input  logic              smp_bit,
  input  logic [1:0]        ctl_fmt,
  input  logic              ctl_lsb_first,
  input  logic [SRX_LW-1:0] ctl_len,
  input  logic              ctl_pack,
  output logic              word_vld,
  output logic [SRX_DW-1:0] word_data,
  output frame_cfg_t        word_cfg,
  output frame_cfg_t        cur_cfg,
  output logic              busy,
  output logic [SRX_NW-1:0] bit_cnt
);

  frame_cfg_t        cfg_q, cfg_n, start_cfg, wcfg_q, wcfg_n;
  logic [SRX_DW-1:0] sh_q, sh_n, word_q, word_n;
  logic [SRX_NW-1:0] cnt_q, cnt_n, cnt_inc;
  logic              busy_q, busy_n, done_q, done_n;

  always_comb begin
    start_cfg.fmt       = fmt_e'(ctl_fmt);
    start_cfg.lsb_first = ctl_lsb_first;
    start_cfg.pack      = ctl_pack;
    if (ctl_fmt[1])
      start_cfg.nbits = SRX_NW'(SRX_CW);
    else if (ctl_len < SRX_LW'(2))
      start_cfg.nbits = SRX_NW'(3);
    else
      start_cfg.nbits = {1'b0, ctl_len} + SRX_NW'(1);
  end

  assign cnt_inc = cnt_q + SRX_NW'(1);

  always_comb begin
    cfg_n  = cfg_q;
    sh_n   = sh_q;
    cnt_n  = cnt_q;
    busy_n = busy_q;
    done_n = 1'b0;
    word_n = word_q;
    wcfg_n = wcfg_q;
    if (smp_stb) begin
      if (smp_fs) begin
        cfg_n  = start_cfg;
        sh_n   = ctl_lsb_first ? {smp_bit, {(SRX_DW-1){1'b0}}}
                               : {{(SRX_DW-1){1'b0}}, smp_bit};
        cnt_n  = SRX_NW'(1);
        busy_n = 1'b1;
      end else if (busy_q) begin
        sh_n  = cfg_q.lsb_first ? {smp_bit, sh_q[SRX_DW-1:1]}
                                : {sh_q[SRX_DW-2:0], smp_bit};
        cnt_n = cnt_inc;
        if (cnt_inc == cfg_q.nbits) begin
          busy_n = 1'b0;
          done_n = 1'b1;
          cnt_n  = '0;
          wcfg_n = cfg_q;
          word_n = cfg_q.lsb_first ? (sh_n >> (SRX_NW'(SRX_DW) - cfg_q.nbits))
                                   : sh_n;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      sh_q   <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      word_q <= '0;
      wcfg_q <= '0;
    end else begin
      cfg_q  <= cfg_n;
      sh_q   <= sh_n;
      cnt_q  <= cnt_n;
      busy_q <= busy_n;
      done_q <= done_n;
      word_q <= word_n;
      wcfg_q <= wcfg_n;
    end
  end

  assign word_vld  = done_q;
  assign word_data = word_q;
  assign word_cfg  = wcfg_q;
  assign cur_cfg   = cfg_q;
  assign busy      = busy_q;
  assign bit_cnt   = cnt_q;

endmodule

// File: rtl/serrx_fmt.sv
module serrx_fmt
  import serrx_pkg::*;
(
  input  logic [SRX_DW-1:0] word_data,
  input  frame_cfg_t        word_cfg,
  output logic [SRX_DW-1:0] fmt_data
);

  logic [SRX_DW-1:0] hi_mask, top_v;
  logic [15:0]       lin;

  always_comb begin
    hi_mask = {SRX_DW{1'b1}} << word_cfg.nbits;
    top_v   = word_data >> (word_cfg.nbits - SRX_NW'(1));
    lin     = '0;
    case (word_cfg.fmt)
      FMT_ZERO:  fmt_data = word_data & ~hi_mask;
      FMT_SIGN:  fmt_data = top_v[0] ? (word_data | hi_mask) : (word_data & ~hi_mask);
      FMT_MULAW: begin
        lin      = mulaw_to_lin(word_data[SRX_CW-1:0]);
        fmt_data = {{(SRX_DW-16){lin[15]}}, lin};
      end
      default: begin
        lin      = alaw_to_lin(word_data[SRX_CW-1:0]);
        fmt_data = {{(SRX_DW-16){lin[15]}}, lin};
      end
    endcase
  end

endmodule

// File: rtl/serrx_pack.sv
module serrx_pack
  import serrx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_vld,
  input  logic              pack_en,
  input  logic [SRX_DW-1:0] fmt_data,
  output logic [SRX_DW-1:0] rx_data,
  output logic              rx_valid,
  output logic              pack_half
);

  logic              half_q, half_n, vld_q, vld_n;
  logic [SRX_HW-1:0] lo_q, lo_n;
  logic [SRX_DW-1:0] data_q, data_n;

  always_comb begin
    half_n = half_q;
    lo_n   = lo_q;
    data_n = data_q;
    vld_n  = 1'b0;
    if (word_vld) begin
      if (pack_en && !half_q) begin
        lo_n   = fmt_data[SRX_HW-1:0];
        half_n = 1'b1;
      end else begin
        data_n = pack_en ? {fmt_data[SRX_HW-1:0], lo_q} : fmt_data;
        vld_n  = 1'b1;
        half_n = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q <= 1'b0;
      lo_q   <= '0;
      data_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      half_q <= half_n;
      lo_q   <= lo_n;
      data_q <= data_n;
      vld_q  <= vld_n;
    end
  end

  assign rx_data   = data_q;
  assign rx_valid  = vld_q;
  assign pack_half = half_q;

endmodule

// File: rtl/serrx_top.sv
module serrx_top
  import serrx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  ctl_fmt,
  input  logic        ctl_lsb_first,
  input  logic [4:0]  ctl_len,
  input  logic        ctl_pack,
  input  logic        ctl_rise,
  input  logic        ctl_int_clk,
  input  logic        sclk_ext,
  input  logic        sclk_int,
  input  logic        fs_in,
  input  logic        sd_in,
  output logic [31:0] rx_data,
  output logic        rx_valid
);

  logic              smp_stb, smp_fs, smp_bit;
  logic              word_vld, busy, pack_half;
  logic [SRX_DW-1:0] word_data, fmt_data;
  logic [SRX_NW-1:0] bit_cnt;
  frame_cfg_t        word_cfg, cur_cfg;

  serrx_edge u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .sclk_ext (sclk_ext),
    .sclk_int (sclk_int),
    .sel_int  (ctl_int_clk),
    .rise_sel (ctl_rise),
    .fs_in    (fs_in),
    .sd_in    (sd_in),
    .smp_stb  (smp_stb),
    .smp_fs   (smp_fs),
    .smp_bit  (smp_bit)
  );

  serrx_shift u_shift (
    .clk           (clk),
    .rst_n         (rst_n),
    .smp_stb       (smp_stb),
    .smp_fs        (smp_fs),
    .smp_bit       (smp_bit),
    .ctl_fmt       (ctl_fmt),
    .ctl_lsb_first (ctl_lsb_first),
    .ctl_len       (ctl_len),
    .ctl_pack      (ctl_pack),
    .word_vld      (word_vld),
    .word_data     (word_data),
    .word_cfg      (word_cfg),
    .cur_cfg       (cur_cfg),
    .busy          (busy),
    .bit_cnt       (bit_cnt)
  );

  serrx_fmt u_fmt (
    .word_data (word_data),
    .word_cfg  (word_cfg),
    .fmt_data  (fmt_data)
  );

  serrx_pack u_pack (
    .clk       (clk),
    .rst_n     (rst_n),
    .word_vld  (word_vld),
    .pack_en   (word_cfg.pack),
    .fmt_data  (fmt_data),
    .rx_data   (rx_data),
    .rx_valid  (rx_valid),
    .pack_half (pack_half)
  );

endmodule

// File: rtl/serrx_chk.sv
module serrx_chk
  import serrx_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              smp_stb,
  input logic              smp_fs,
  input logic              word_vld,
  input logic              busy,
  input logic              pack_half,
  input logic [SRX_NW-1:0] bit_cnt,
  input frame_cfg_t        cur_cfg,
  input frame_cfg_t        word_cfg,
  input logic [31:0]       rx_data,
  input logic              rx_valid
);

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid); // R13

  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |-> $stable(rx_data)); // R13

  AST_VALID_FROM_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(word_vld)); // R13

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (bit_cnt != '0 && bit_cnt < cur_cfg.nbits)); // R2

  AST_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_stb && smp_fs) |=> (busy && bit_cnt == SRX_NW'(1))); // R11

  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !(smp_stb && smp_fs)) |=> $stable(cur_cfg)); // R12

  AST_PACK_FIRST_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (word_vld && word_cfg.pack && !pack_half) |=> !rx_valid); // R10

  AST_COMPAND_SEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && $past(word_cfg.fmt[1] && !word_cfg.pack))
      |-> ($countones(rx_data[31:15]) == 0 || $countones(rx_data[31:15]) == 17)); // R8

endmodule

bind serrx_top serrx_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .smp_stb   (smp_stb),
  .smp_fs    (smp_fs),
  .word_vld  (word_vld),
  .busy      (busy),
  .pack_half (pack_half),
  .bit_cnt   (bit_cnt),
  .cur_cfg   (cur_cfg),
  .word_cfg  (word_cfg),
  .rx_data   (rx_data),
  .rx_valid  (rx_valid)
);

// File: tb/serrx_top_tb.sv
module serrx_top_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n;
  logic [1:0]  ctl_fmt;
  logic        ctl_lsb_first, ctl_pack, ctl_rise, ctl_int_clk;
  logic [4:0]  ctl_len;
  logic        sclk_ext, sclk_int, fs_in, sd_in;
  logic [31:0] rx_data;
  logic        rx_valid;

  int n_checks = 0;
  int n_fails  = 0;
  int vcount   = 0;
  logic [31:0] last_data = '0;

  serrx_top u_dut (
    .clk(clk), .rst_n(rst_n), .ctl_fmt(ctl_fmt), .ctl_lsb_first(ctl_lsb_first),
    .ctl_len(ctl_len), .ctl_pack(ctl_pack), .ctl_rise(ctl_rise),
    .ctl_int_clk(ctl_int_clk), .sclk_ext(sclk_ext), .sclk_int(sclk_int),
    .fs_in(fs_in), .sd_in(sd_in), .rx_data(rx_data), .rx_valid(rx_valid)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (rx_valid) begin
      vcount    = vcount + 1;
      last_data = rx_data;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_sclk(input logic lvl);
    if (ctl_int_clk) sclk_int = lvl;
    else             sclk_ext = lvl;
  endtask

  // Data is inverted around the inactive transition so a wrong edge is visible.
  task automatic drive_bit(input logic f, input logic b);
    set_sclk(~ctl_rise); wait_clk(3);
    fs_in = f;  sd_in = b;  wait_clk(3);
    set_sclk(ctl_rise);     wait_clk(3);
    fs_in = ~f; sd_in = ~b; wait_clk(3);
  endtask

  task automatic send_word(input logic [31:0] val, input int n);
    for (int i = 0; i < n; i++)
      drive_bit(i == 0, ctl_lsb_first ? val[i] : val[n-1-i]);
    fs_in = 1'b0; sd_in = 1'b0;
    wait_clk(6);
  endtask

  task automatic setup(input logic [1:0] f, input logic lsb, input logic [4:0] len,
                       input logic pk);
    ctl_fmt = f; ctl_lsb_first = lsb; ctl_len = len; ctl_pack = pk;
  endtask

  task automatic t_reset;
    check("R1 rx_valid after reset", {31'd0, rx_valid}, 32'd0);
    check("R1 rx_data after reset", rx_data, 32'd0);
  endtask

  task automatic t_msb_zero;
    int v0;
    setup(2'b00, 1'b0, 5'd7, 1'b0);
    v0 = vcount;
    send_word(32'hA5, 8);
    check("R2 R6 msb-first 8-bit zero-fill", last_data, 32'h0000_00A5);
    check("R13 exactly one strobe cycle", vcount - v0, 32'd1);
    wait_clk(20);
    check("R13 data held after strobe", rx_data, 32'h0000_00A5);
  endtask

  task automatic t_lsb;
    setup(2'b00, 1'b1, 5'd11, 1'b0);
    send_word(32'h9C3, 12);
    check("R3 lsb-first 12-bit", last_data, 32'h0000_09C3);
    setup(2'b00, 1'b1, 5'd7, 1'b0);
    send_word(32'h01, 8);
    check("R3 lsb-first single low bit", last_data, 32'h0000_0001);
  endtask

  task automatic t_len_edges;
    int v0;
    setup(2'b00, 1'b0, 5'd31, 1'b0);
    send_word(32'hDEAD_BEEF, 32);
    check("R2 32-bit word", last_data, 32'hDEAD_BEEF);
    setup(2'b00, 1'b0, 5'd0, 1'b0);
    v0 = vcount;
    send_word(32'h5, 3);
    check("R2 length field 0 gives 3 bits", last_data, 32'h0000_0005);
    check("R2 one word for 3 bits", vcount - v0, 32'd1);
  endtask

  task automatic t_sign;
    setup(2'b01, 1'b0, 5'd11, 1'b0);
    send_word(32'h8F0, 12);
    check("R7 sign-extend negative", last_data, 32'hFFFF_F8F0);
    send_word(32'h7F0, 12);
    check("R7 sign-extend positive", last_data, 32'h0000_07F0);
  endtask

  task automatic t_fall;
    ctl_rise = 1'b0;
    setup(2'b00, 1'b0, 5'd7, 1'b0);
    send_word(32'h3C, 8);
    check("R4 falling-edge sampling", last_data, 32'h0000_003C);
    ctl_rise = 1'b1;
    send_word(32'hC6, 8);
    check("R4 rising-edge sampling restored", last_data, 32'h0000_00C6);
  endtask

  task automatic t_intclk;
    sclk_ext = 1'b0;
    ctl_int_clk = 1'b1;
    setup(2'b00, 1'b0, 5'd7, 1'b0);
    send_word(32'h5A, 8);
    check("R5 internal clock selected", last_data, 32'h0000_005A);
    sclk_int = 1'b0;
    ctl_int_clk = 1'b0;
  endtask

  task automatic t_mulaw;
    setup(2'b10, 1'b0, 5'd15, 1'b0);
    send_word(32'h00, 8);
    check("R8 mu-law 0x00", last_data, 32'hFFFF_8284);
    send_word(32'h80, 8);
    check("R8 mu-law 0x80", last_data, 32'h0000_7D7C);
    send_word(32'hFF, 8);
    check("R8 mu-law 0xFF", last_data, 32'h0000_0000);
  endtask

  task automatic t_alaw;
    setup(2'b11, 1'b0, 5'd3, 1'b0);
    send_word(32'hD5, 8);
    check("R9 A-law 0xD5", last_data, 32'h0000_0008);
    send_word(32'hAA, 8);
    check("R9 A-law 0xAA", last_data, 32'h0000_7E00);
    send_word(32'h2A, 8);
    check("R9 A-law 0x2A", last_data, 32'hFFFF_8200);
  endtask

  task automatic t_pack;
    int v0;
    setup(2'b00, 1'b0, 5'd15, 1'b1);
    v0 = vcount;
    send_word(32'h1234, 16);
    check("R10 no strobe after first packed word", vcount - v0, 32'd0);
    send_word(32'hABCD, 16);
    check("R10 packed output", last_data, 32'hABCD_1234);
    check("R10 one strobe per pair", vcount - v0, 32'd1);
  endtask

  task automatic t_abort;
    int v0;
    setup(2'b00, 1'b0, 5'd11, 1'b0);
    v0 = vcount;
    for (int i = 0; i < 5; i++) drive_bit(i == 0, 1'b1);
    send_word(32'h123, 12);
    check("R11 restarted word", last_data, 32'h0000_0123);
    check("R11 partial word gives no strobe", vcount - v0, 32'd1);
  endtask

  task automatic t_cfg_latch;
    logic [7:0] w;
    w = 8'hA5;
    setup(2'b00, 1'b0, 5'd7, 1'b0);
    for (int i = 0; i < 3; i++) drive_bit(i == 0, w[7-i]);
    setup(2'b01, 1'b1, 5'd3, 1'b0);
    for (int i = 3; i < 8; i++) drive_bit(1'b0, w[7-i]);
    fs_in = 1'b0; sd_in = 1'b0;
    wait_clk(6);
    check("R12 mid-word control change ignored", last_data, 32'h0000_00A5);
  endtask

  initial begin
    rst_n = 1'b0;
    ctl_fmt = 2'b00; ctl_lsb_first = 1'b0; ctl_len = 5'd7; ctl_pack = 1'b0;
    ctl_rise = 1'b1; ctl_int_clk = 1'b0;
    sclk_ext = 1'b0; sclk_int = 1'b0; fs_in = 1'b0; sd_in = 1'b0;
    wait_clk(4);
    t_reset();
    rst_n = 1'b1;
    wait_clk(3);
    t_reset();
    t_msb_zero();
    t_lsb();
    t_len_edges();
    t_sign();
    t_fall();
    t_intclk();
    t_mulaw();
    t_alaw();
    t_pack();
    t_abort();
    t_cfg_latch();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

endmodule